// File: doc/BRIEF.md
# Serial Port Data Buffer Register Interface

This block sits between a byte-wide register bus and the serial shifters of a universal synchronous/asynchronous serial port. A single data address serves two directions. A write to it fills a one-byte transmit holding buffer. A read from it pops the oldest character from a two-entry receive queue. A second address holds a status byte. That byte reports whether the receive queue has data, whether transmission has completed, whether the holding buffer can take a byte, and the error flags of the character at the head of the queue. It also holds two writable mode bits.

The transmit side hands the held byte to an external shift register as soon as that register reports empty and the transmitter is enabled. The receive side stores each incoming character with its frame, overrun and parity flags. If the queue is full, the character is dropped and the loss is recorded on the next stored character. Software sets a character size of 5 to 8 bits, and bits above that size are masked in both directions.

Top module: `usart_dbuf`

## Requirements
- R1: A write to address DATA_ADDR (default 0) goes to the transmit holding buffer. A read of DATA_ADDR returns the character at the head of the receive queue.
- R2: A write to DATA_ADDR while `dreg_empty` is 0 is discarded and does not change the byte later handed to the shifter.
- R3: While the holding buffer is full, `tx_en` is 1 and `sh_empty` is 1, the next clock edge raises `sh_load` for one cycle with the held byte on `sh_data` and returns `dreg_empty` to 1.
- R4: The receive queue holds two characters in arrival order. Each read of DATA_ADDR that finds it non-empty removes one entry. A push and a pop in the same cycle are both honoured.
- R5: `rx_complete` is 1 exactly when the receive queue holds at least one entry.
- R6: While `rx_en` is 0 the receive queue is emptied and incoming characters are ignored, so `rx_complete` is 0 one cycle later.
- R7: `char_sz` encodes 0=5 bits, 1=6 bits, 2=7 bits, 3=8 bits. Data bits at or above the size are cleared on the byte handed to the shifter and on received data read back.
- R8: A read of STAT_ADDR (default 1) returns bit 7 rx_complete, bit 6 tx_complete, bit 5 dreg_empty, bit 4 frame error, bit 3 overrun, bit 2 parity error, bit 1 double speed, bit 0 multi-processor mode. After reset it reads 0x20.
- R9: A write to STAT_ADDR loads bits 1 and 0 (`dbl_speed`, `mpc_mode`). It leaves bits 7, 5, 4, 3 and 2 unchanged.
- R10: The three error bits describe the head entry only, follow it as the queue pops, and read 0 when the queue is empty.
- R11: A character that arrives while the queue holds two entries is dropped. The overrun bit of the next stored character is set, and it is also set when `rx_oerr` accompanies a character.
- R12: `tx_complete` is set by an `sh_done` pulse while the holding buffer is empty. A write to STAT_ADDR with bit 6 at 1 clears it, and a simultaneous set wins.
- R13: `bus_rdata` is registered and is valid the cycle after `bus_rd`, holding its value otherwise. A read of DATA_ADDR with an empty queue returns 0 and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| char_sz | input | 2 | Character size code |
| sh_empty | input | 1 | Transmit shift register is empty |
| sh_done | input | 1 | Pulse: shift register finished a frame |
| sh_load | output | 1 | Pulse: byte handed to shift register |
| sh_data | output | 8 | Byte handed to shift register |
| rx_valid | input | 1 | Pulse: received character available |
| rx_data | input | 8 | Received character |
| rx_ferr | input | 1 | Frame error of received character |
| rx_oerr | input | 1 | Overrun reported by receiver |
| rx_perr | input | 1 | Parity error of received character |
| rx_complete | output | 1 | Receive queue not empty |
| dreg_empty | output | 1 | Transmit holding buffer can accept a byte |
| tx_complete | output | 1 | Transmission complete flag |
| dbl_speed | output | 1 | Double-speed mode bit |
| mpc_mode | output | 1 | Multi-processor mode bit |

## Verification
The hardest situation to reach is the overrun path. The queue must be full when a third character arrives, and the recorded loss must show up on a later character whose head position becomes visible only after earlier pops. The stimulus pushes three characters with different error flags while no reads occur, then reads status and data alternately, pushes a fourth character, and reads again. A same-cycle push and pop at one entry, and a disable with the queue full, are also driven. A behavioural queue model follows every cycle.

// File: rtl/usart_dbuf_pkg.sv
package usart_dbuf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              fe;
    logic              ov;
    logic              pe;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  // size code: 0..3 -> 5..8 data bits
  function automatic logic [BYTE_W-1:0] size_mask(input logic [1:0] sz);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = (i < 5 + int'(sz));
    return m;
  endfunction
endpackage

// File: rtl/usart_dbuf_txhold.sv
module usart_dbuf_txhold
  import usart_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [1:0]        sz,
  input  logic              tx_en,
  input  logic              sh_empty,
  input  logic              sh_done,
  input  logic              txc_clr,
  output logic              empty_o,
  output logic              sh_load,
  output logic [BYTE_W-1:0] sh_data,
  output logic              txc
);
  logic              full;
  logic [BYTE_W-1:0] hold;
  logic              take;
  logic              load_now;

  assign take     = wr_en && !full;
  assign load_now = full && tx_en && sh_empty;
  assign empty_o  = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      hold    <= '0;
      sh_load <= 1'b0;
      sh_data <= '0;
      txc     <= 1'b0;
    end else begin
      sh_load <= load_now;
      if (take) begin
        full <= 1'b1;
        hold <= wdata & size_mask(sz);
      end else if (load_now) begin
        full    <= 1'b0;
        sh_data <= hold;
      end
      if (sh_done && !full) txc <= 1'b1;
      else if (txc_clr)     txc <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_dbuf_rxq.sv
module usart_dbuf_rxq
  import usart_dbuf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output logic      empty,
  output logic      full,
  output rx_entry_t head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t          mem [DEPTH];
  logic [PTR_W-1:0]   wptr, rptr;
  logic [CNT_W-1:0]   count;
  logic               do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/usart_dbuf.sv
module usart_dbuf
  import usart_dbuf_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int RX_DEPTH  = 2,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [1:0]        char_sz,
  input  logic              sh_empty,
  input  logic              sh_done,
  output logic              sh_load,
  output logic [7:0]        sh_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_ferr,
  input  logic              rx_oerr,
  input  logic              rx_perr,
  output logic              rx_complete,
  output logic              dreg_empty,
  output logic              tx_complete,
  output logic              dbl_speed,
  output logic              mpc_mode
);
  logic      sel_data, sel_stat;
  logic      q_empty, q_full, q_push, q_pop;
  logic      ovr_pend;
  rx_entry_t q_head, q_din;
  logic [7:0] stat_byte;

  assign sel_data = (bus_addr == ADDR_W'(DATA_ADDR));
  assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));

  usart_dbuf_txhold u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && sel_data),
    .wdata    (bus_wdata),
    .sz       (char_sz),
    .tx_en    (tx_en),
    .sh_empty (sh_empty),
    .sh_done  (sh_done),
    .txc_clr  (bus_wr && sel_stat && bus_wdata[6]),
    .empty_o  (dreg_empty),
    .sh_load  (sh_load),
    .sh_data  (sh_data),
    .txc      (tx_complete)
  );

  assign q_push     = rx_valid && rx_en;
  assign q_pop      = bus_rd && sel_data;
  assign q_din.fe   = rx_ferr;
  assign q_din.ov   = rx_oerr || ovr_pend;
  assign q_din.pe   = rx_perr;
  assign q_din.data = rx_data & size_mask(char_sz);

  usart_dbuf_rxq #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (!rx_en),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .empty (q_empty),
    .full  (q_full),
    .head  (q_head)
  );

  assign rx_complete = !q_empty;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)        ovr_pend <= 1'b0;
    else if (q_push && q_full) ovr_pend <= 1'b1;
    else if (q_push)           ovr_pend <= 1'b0;
  end

  always_comb begin
    stat_byte = {rx_complete, tx_complete, dreg_empty,
                 q_head.fe & rx_complete, q_head.ov & rx_complete,
                 q_head.pe & rx_complete, dbl_speed, mpc_mode};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      dbl_speed <= 1'b0;
      mpc_mode  <= 1'b0;
    end else begin
      if (bus_rd) begin
        if (sel_data)      bus_rdata <= q_empty ? 8'h00 : q_head.data;
        else if (sel_stat) bus_rdata <= stat_byte;
        else               bus_rdata <= 8'h00;
      end
      if (bus_wr && sel_stat) begin
        dbl_speed <= bus_wdata[1];
        mpc_mode  <= bus_wdata[0];
      end
    end
  end
endmodule

// File: rtl/usart_dbuf_chk.sv
module usart_dbuf_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       rx_en,
  input logic       sh_empty,
  input logic       sh_load,
  input logic       rx_valid,
  input logic       rx_complete,
  input logic       dreg_empty,
  input logic       tx_complete
);
  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dreg_empty && !rx_complete && !tx_complete && !sh_load));

  // R3
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (!dreg_empty && tx_en && sh_empty) |=> sh_load);

  // R3
  load_frees_chk: assert property (@(posedge clk) disable iff (rst)
    sh_load |-> dreg_empty);

  // R2
  held_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!dreg_empty && !(tx_en && sh_empty)) |=> (!dreg_empty && !sh_load));

  // R6
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_complete);

  // R5
  rxc_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_complete) |-> $past(rx_valid && rx_en));
endmodule

bind usart_dbuf usart_dbuf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .sh_empty    (sh_empty),
  .sh_load     (sh_load),
  .rx_valid    (rx_valid),
  .rx_complete (rx_complete),
  .dreg_empty  (dreg_empty),
  .tx_complete (tx_complete)
);

// File: tb/sim_usart_dbuf.sv
`timescale 1ns/1ps
module sim_usart_dbuf;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       tx_en = 0, rx_en = 0;
  logic [1:0] char_sz = 3;
  logic       sh_empty = 0, sh_done = 0;
  logic       sh_load;
  logic [7:0] sh_data;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic       rx_ferr = 0, rx_oerr = 0, rx_perr = 0;
  logic       rx_complete, dreg_empty, tx_complete, dbl_speed, mpc_mode;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  usart_dbuf u0 (.*);

  // ---------------- reference model ----------------
  logic [10:0] mq[$];  // {fe, ov, pe, data}
  bit   m_pend, m_full, m_load, m_txc, m_u2x, m_mpcm;
  logic [7:0] m_hold, m_shd, m_rd;

  function automatic logic [7:0] msk(input logic [1:0] s);
    case (s)
      2'd0: return 8'h1F;
      2'd1: return 8'h3F;
      2'd2: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] m_stat();
    logic [2:0] e;
    e = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
    return {mq.size() > 0, m_txc, !m_full, e, m_u2x, m_mpcm};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_pend = 0; m_full = 0; m_load = 0; m_txc = 0;
      m_u2x = 0; m_mpcm = 0; m_hold = 0; m_shd = 0; m_rd = 0;
    end else begin
      bit was_full, ld;
      int sz0;
      was_full = m_full;
      sz0 = mq.size();
      if (bus_rd) begin
        if (bus_addr == 0)      m_rd = (sz0 > 0) ? mq[0][7:0] : 8'h00;
        else if (bus_addr == 1) m_rd = m_stat();
        else                    m_rd = 8'h00;
      end
      ld = m_full && tx_en && sh_empty;
      m_load = ld;
      if (bus_wr && bus_addr == 0 && !m_full) begin
        m_full = 1; m_hold = bus_wdata & msk(char_sz);
      end else if (ld) begin
        m_full = 0; m_shd = m_hold;
      end
      if (sh_done && !was_full) m_txc = 1;
      else if (bus_wr && bus_addr == 1 && bus_wdata[6]) m_txc = 0;
      if (bus_wr && bus_addr == 1) begin
        m_u2x = bus_wdata[1]; m_mpcm = bus_wdata[0];
      end
      if (!rx_en) begin
        mq.delete(); m_pend = 0;
      end else begin
        if (bus_rd && bus_addr == 0 && sz0 > 0) void'(mq.pop_front());
        if (rx_valid) begin
          if (sz0 < 2) begin
            mq.push_back({rx_ferr, rx_oerr | m_pend, rx_perr, rx_data & msk(char_sz)});
            m_pend = 0;
          end else m_pend = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_rdata == m_rd, "R13 rdata", bus_rdata, m_rd);
      chk(sh_load == m_load, "R3 sh_load", sh_load, m_load);
      chk(sh_data == m_shd, "R7 sh_data", sh_data, m_shd);
      chk(rx_complete == (mq.size() > 0), "R5 rx_complete", rx_complete, mq.size() > 0);
      chk(dreg_empty == !m_full, "R2 dreg_empty", dreg_empty, !m_full);
      chk(tx_complete == m_txc, "R12 tx_complete", tx_complete, m_txc);
      chk({dbl_speed, mpc_mode} == {m_u2x, m_mpcm}, "R9 mode bits",
          {dbl_speed, mpc_mode}, {m_u2x, m_mpcm});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic push(input logic [7:0] d, input bit f, input bit o, input bit p);
    rx_valid = 1; rx_data = d; rx_ferr = f; rx_oerr = o; rx_perr = p;
    @(negedge clk);
    rx_valid = 0; rx_ferr = 0; rx_oerr = 0; rx_perr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset value
    rd_chk(3'd1, 8'h20, "R8 reset status");

    // R1 R2: write held with transmitter off, second write dropped
    wr(3'd0, 8'hA5);
    chk(dreg_empty == 0, "R1 write fills buffer", dreg_empty, 0);
    wr(3'd0, 8'h3C);
    rd_chk(3'd1, 8'h00, "R2 status while full");
    tx_en = 1; sh_empty = 1;
    @(negedge clk);
    chk(sh_load && sh_data == 8'hA5, "R3 handoff of first byte (R2 drop)", sh_data, 8'hA5);
    sh_empty = 0;
    @(negedge clk);

    // R7 five-bit transmit masking
    char_sz = 0;
    wr(3'd0, 8'hFF);
    sh_empty = 1;
    @(negedge clk);
    chk(sh_data == 8'h1F, "R7 tx mask", sh_data, 8'h1F);
    sh_empty = 0; char_sz = 3;
    @(negedge clk);

    // R12 transmit complete set and write-one clear
    sh_done = 1; @(negedge clk); sh_done = 0;
    rd_chk(3'd1, 8'h60, "R12 txc set");
    wr(3'd1, 8'h40);
    chk(tx_complete == 0, "R12 txc cleared", tx_complete, 0);
    // R9 read-only bits ignore writes
    wr(3'd1, 8'hFF);
    rd_chk(3'd1, 8'h23, "R9 status after all-ones write");
    wr(3'd1, 8'h00);

    // R4 R10 R11 receive queue
    rx_en = 1;
    @(negedge clk);
    push(8'h11, 1, 0, 0);
    push(8'h22, 0, 0, 1);
    push(8'h33, 0, 0, 0);            // dropped: queue full
    rd_chk(3'd1, 8'hB0, "R10 head frame error");
    rd_chk(3'd0, 8'h11, "R4 first out");
    rd_chk(3'd1, 8'hA4, "R10 head parity error");
    push(8'h44, 0, 0, 0);
    rd_chk(3'd0, 8'h22, "R4 second out");
    rd_chk(3'd1, 8'hA8, "R11 overrun on next entry");
    rd_chk(3'd0, 8'h44, "R11 entry after drop");
    rd_chk(3'd0, 8'h00, "R13 empty read");
    rd_chk(3'd1, 8'h20, "R10 flags clear when empty");

    // R7 six-bit receive masking
    char_sz = 1;
    push(8'hFF, 0, 0, 0);
    rd_chk(3'd0, 8'h3F, "R7 rx mask");
    char_sz = 3;

    // R4 simultaneous push and pop at one entry
    push(8'h55, 0, 0, 0);
    bus_addr = 0; bus_rd = 1; rx_valid = 1; rx_data = 8'h66;
    @(negedge clk);
    bus_rd = 0; rx_valid = 0;
    chk(bus_rdata == 8'h55, "R4 pop during push", bus_rdata, 8'h55);
    rd_chk(3'd0, 8'h66, "R4 pushed entry kept");

    // R6 flush on disable
    push(8'h77, 0, 1, 0);
    push(8'h88, 0, 0, 0);
    rx_en = 0;
    @(negedge clk);
    chk(rx_complete == 0, "R6 flush", rx_complete, 0);
    push(8'h99, 0, 0, 0);             // ignored while disabled
    rx_en = 1;
    @(negedge clk);
    rd_chk(3'd0, 8'h00, "R6 nothing stored while disabled");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule